// File: doc/BRIEF.md
# Interrupt Status Bank with Wake-up Gating

This block holds five latched interrupt causes for an audio-link DMA controller. Four cause inputs are one-cycle pulses: a link wake-up, a playback FIFO under-run, the end of the current descriptor and the end of the final descriptor. The fifth is a level flag raised by the codec's GPIO logic. Each latched bit is paired with an enable bit supplied by a neighbouring control register. A single registered interrupt line is raised when any enabled bit is set. Software acknowledges a cause by writing a 1 to its bit position.

The wake-up bit follows extra rules. It can only be latched while the link shut-off control is high. Once latched, a write-1 acknowledge takes effect only after shut-off has been lowered. The wake-up bit sits in an always-on domain with its own reset, so it keeps its value through a main-power reset.

Top module: `irq_status_bank`

## Requirements
- R1: Status bit positions are: bit 4 wake-up, bit 3 FIFO under-run, bit 2 current-descriptor end, bit 1 final-descriptor end, bit 0 codec GPIO. A pulse on an event input sets its bit at the next clock edge, and the other bits are unchanged.
- R2: A write with `wr_en`=1 clears every bit whose `wr_data` bit is 1. Bits written with 0 keep their value.
- R3: Asserting `rst_n` alone clears bits 3..0 and `irq` but leaves bit 4 unchanged.
- R4: While `link_shutoff` is 0, a wake-up pulse does not set bit 4.
- R5: While `link_shutoff` is 1, a write-1 to bit 4 does not clear it. Once `link_shutoff` is 0, the same write clears it.
- R6: Bit 0 is set at every edge where `codec_gpio_flag` is 1, so it stays set while the flag is high, even under a write-1 clear.
- R7: `irq` is, one clock after the fact, the OR over all bits of status AND `irq_en`.
- R8: When an event and a write-1 clear of the same bit arrive in the same cycle, the bit ends up set.
- R9: Once `rst_n` and `aon_rst_n` are both asserted, all status bits are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Main-domain asynchronous reset, active low |
| aon_rst_n | input | 1 | Always-on-domain asynchronous reset, active low, for the wake-up bit |
| link_shutoff | input | 1 | Link shut-off control; gates wake-up set and clear |
| evt_wake | input | 1 | Link wake-up event pulse |
| evt_underrun | input | 1 | Playback FIFO under-run pulse |
| evt_cur_end | input | 1 | Current descriptor fully fetched pulse |
| evt_last_end | input | 1 | Final descriptor fully fetched pulse |
| codec_gpio_flag | input | 1 | Codec GPIO interrupt flag, level |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 5 | Write-1-to-clear mask |
| irq_en | input | 5 | Per-bit interrupt enables |
| status | output | 5 | Latched status bits |
| irq | output | 1 | Combined registered interrupt |

## Verification
The hardest situation to reach is a wake-up bit that survives a main reset while the link is shut off, and is then acknowledged. The stimulus raises shut-off, pulses the wake event, pulses only the main reset, and tries to clear the bit with shut-off still high. It then lowers shut-off and repeats the clear. This sequence covers the set gate, the clear gate and the split reset domains on one bit. A second corner is an event pulse that lands on the same edge as its own write-1 clear, which the stimulus produces by driving both before a single edge.

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NBITS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aon_rst_n,
  input  logic             link_shutoff,
  input  logic             evt_wake,
  input  logic             evt_underrun,
  input  logic             evt_cur_end,
  input  logic             evt_last_end,
  input  logic             codec_gpio_flag,
  input  logic             wr_en,
  input  logic [NBITS-1:0] wr_data,
  input  logic [NBITS-1:0] irq_en,
  output logic [NBITS-1:0] status,
  output logic             irq
);
  localparam int WAKE = NBITS - 1;

  logic             wake_q;
  logic [WAKE-1:0]  main_q;
  logic [WAKE-1:0]  main_set;
  logic [WAKE-1:0]  main_clr;
  logic             wake_set;
  logic             wake_clr;

  assign main_set = {evt_underrun, evt_cur_end, evt_last_end, codec_gpio_flag};
  assign main_clr = wr_en ? wr_data[WAKE-1:0] : '0;
  assign wake_set = evt_wake & link_shutoff;
  assign wake_clr = wr_en & wr_data[WAKE] & ~link_shutoff;

  always_ff @(posedge clk or negedge aon_rst_n)
    if (!aon_rst_n) wake_q <= 1'b0;
    else            wake_q <= wake_set | (wake_q & ~wake_clr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) main_q <= '0;
    else        main_q <= main_set | (main_q & ~main_clr);

  assign status = {wake_q, main_q};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(status & irq_en);
endmodule

// File: rtl/irq_status_bank_chk.sv
module irq_status_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       aon_rst_n,
  input logic       link_shutoff,
  input logic       evt_wake,
  input logic       evt_underrun,
  input logic       codec_gpio_flag,
  input logic       wr_en,
  input logic [4:0] wr_data,
  input logic [4:0] irq_en,
  input logic [4:0] status,
  input logic       irq
);
  // R4
  a_r4_wake_gated: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (!link_shutoff && !status[4]) |=> !status[4]);
  // R5
  a_r5_wake_held: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (link_shutoff && status[4]) |=> status[4]);
  // R2
  a_r2_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !(wr_en && wr_data[3])) |=> status[3]);
  // R8
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_underrun |=> status[3]);
  // R6
  a_r6_gpio_level: assert property (@(posedge clk) disable iff (!rst_n)
    codec_gpio_flag |=> status[0]);
  // R7
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n || !aon_rst_n)
    1'b1 |=> (irq == $past(|(status & irq_en))));
endmodule

bind irq_status_bank irq_status_bank_chk i_chk (
  .clk(clk), .rst_n(rst_n), .aon_rst_n(aon_rst_n), .link_shutoff(link_shutoff),
  .evt_wake(evt_wake), .evt_underrun(evt_underrun), .codec_gpio_flag(codec_gpio_flag),
  .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en), .status(status), .irq(irq)
);

// File: tb/test_irq_status_bank.sv
module test_irq_status_bank;
  logic clk = 0, rst_n = 0, aon_rst_n = 0, link_shutoff = 0;
  logic evt_wake = 0, evt_underrun = 0, evt_cur_end = 0, evt_last_end = 0, codec_gpio_flag = 0;
  logic wr_en = 0;
  logic [4:0] wr_data = 0, irq_en = 0;
  logic [4:0] status;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_status_bank i_irq_status_bank (.*);

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse(logic [4:0] ev);
    {evt_wake, evt_underrun, evt_cur_end, evt_last_end, codec_gpio_flag} = ev;
    tick();
    {evt_wake, evt_underrun, evt_cur_end, evt_last_end, codec_gpio_flag} = '0;
  endtask

  task automatic wr(logic [4:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0; wr_data = 0;
  endtask

  task automatic t_reset();
    tick(); tick();
    check("R9 reset status", {1'b0, status}, 6'b0);
    check("R9 reset irq", {5'b0, irq}, 6'b0);
    rst_n = 1; aon_rst_n = 1; tick();
  endtask

  task automatic t_positions();
    pulse(5'b01000); check("R1 underrun bit3", {1'b0, status}, 6'b001000);
    pulse(5'b00100); check("R1 cur end bit2", {1'b0, status}, 6'b001100);
    pulse(5'b00010); check("R1 last end bit1", {1'b0, status}, 6'b001110);
    pulse(5'b00001); check("R1 gpio bit0", {1'b0, status}, 6'b001111);
  endtask

  task automatic t_w1c();
    wr(5'b00000); check("R2 write zero no effect", {1'b0, status}, 6'b001111);
    wr(5'b00100); check("R2 clear bit2 only", {1'b0, status}, 6'b001011);
    wr(5'b01011); check("R2 clear rest", {1'b0, status}, 6'b0);
  endtask

  task automatic t_set_wins();
    evt_underrun = 1; wr_en = 1; wr_data = 5'b01000; tick();
    evt_underrun = 0; wr_en = 0; wr_data = 0;
    check("R8 set beats clear", {1'b0, status}, 6'b001000);
    wr(5'b01000); check("R8 later clear", {1'b0, status}, 6'b0);
  endtask

  task automatic t_wake_gate();
    link_shutoff = 0; pulse(5'b10000);
    check("R4 wake blocked", {1'b0, status}, 6'b0);
    link_shutoff = 1; pulse(5'b10000);
    check("R1 wake bit4", {1'b0, status}, 6'b010000);
  endtask

  task automatic t_sticky_and_clear();
    rst_n = 0; pulse(5'b01000); tick();
    check("R3 wake survives main reset", {1'b0, status}, 6'b010000);
    rst_n = 1; tick();
    wr(5'b10000); check("R5 clear blocked under shutoff", {1'b0, status}, 6'b010000);
    link_shutoff = 0; tick();
    wr(5'b10000); check("R5 clear after shutoff low", {1'b0, status}, 6'b0);
  endtask

  task automatic t_gpio_level();
    codec_gpio_flag = 1; tick();
    wr(5'b00001); check("R6 held while flag high", {1'b0, status}, 6'b000001);
    codec_gpio_flag = 0; tick();
    wr(5'b00001); check("R6 clear after flag low", {1'b0, status}, 6'b0);
  endtask

  task automatic t_irq();
    irq_en = 5'b00100;
    pulse(5'b00010);
    tick(); check("R7 masked bit no irq", {5'b0, irq}, 6'b0);
    pulse(5'b00100);
    check("R7 irq lags status", {5'b0, irq}, 6'b0);
    tick(); check("R7 irq raised", {5'b0, irq}, 6'b1);
    wr(5'b00100); check("R7 irq still set one cycle", {5'b0, irq}, 6'b1);
    tick(); check("R7 irq dropped", {5'b0, irq}, 6'b0);
    irq_en = 5'b00010; tick(); tick();
    check("R7 enable change raises irq", {5'b0, irq}, 6'b1);
    wr(5'b00010); tick(); irq_en = 0;
  endtask

  task automatic t_full_reset();
    link_shutoff = 1; pulse(5'b10000);
    aon_rst_n = 0; rst_n = 0; tick();
    check("R9 both resets clear all", {1'b0, status}, 6'b0);
    aon_rst_n = 1; rst_n = 1; link_shutoff = 0; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2;
    t_reset();
    t_positions();
    t_w1c();
    t_set_wins();
    t_wake_gate();
    t_sticky_and_clear();
    t_gpio_level();
    t_irq();
    t_full_reset();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule